// File: doc/BRIEF.md
# Selectable-Order Sinc Decimation Filter

This block turns the one-bit output stream of a sigma-delta modulator into 24-bit signed conversion results. Each accepted bit counts as +1 when it is a one and as −1 when it is a zero. The ones density therefore sets the sign and size of the result. The stream passes through a cascade of integrators that run at the input sample rate. A decimator then feeds a cascade of differentiators that run at the output rate. The cascade length is either three or four stages, chosen at run time, which gives a third-order or fourth-order sinc response.

A 10-bit rate word sets the decimation block length to 64 × FS accepted samples. A rate word of zero is treated as one. With the modulator strobe pulsing once every 16 master clocks, the output period comes to 1024 × FS master clocks. The full-precision filter output is divided by its own gain for the active order and length, then rounded and clipped into 24-bit two's complement.

After a reset or a restart pulse, every piece of filter state is cleared. The filter then withholds the outputs of the blocks it has not yet filled completely. The order select and the rate word are taken only at those two moments. Once the filter has settled, it delivers one result per block with a one-clock ready pulse, and it keeps doing so even when the input steps.

Top module: `sinc_decim`

## Requirements
- R1: While reset is applied and after it is released, `res_ready` stays low and `res_data` reads zero until the first valid result.
- R2: An accepted one counts as +1 and a zero as −1. A settled all-ones input yields 24'h7FFFFF, because positive full scale is clipped. A settled all-zeros input yields 24'h800000.
- R3: Once settled, for an input whose ones density d is periodic within the block, the result is round(2^23 × (2d − 1)) in 24-bit two's complement. Densities of 3/4, 5/8, 1/2 and 1/4 give 24'h400000, 24'h200000, 24'h000000 and 24'hC00000.
- R4: One decimation output falls due every 64 × FS accepted samples, where FS is the latched rate word. A rate word of 0 behaves as 1. With one sample every 16 clocks, settled ready pulses come exactly 1024 × FS clocks apart.
- R5: With `order_sel` = 0 (third order), the first two decimation outputs after a reset or a restart are suppressed. The first ready pulse comes from the output that completes 3 × 64 × FS samples.
- R6: With `order_sel` = 1 (fourth order), the first three decimation outputs are suppressed. The first ready pulse comes from the output that completes 4 × 64 × FS samples.
- R7: `res_ready` is high for exactly one clock with each valid result.
- R8: `order_sel` and `rate_word` are sampled only in a clock with `cfg_restart` high and in the first clock after reset. Changes at any other time do not affect the period, the order or the results.
- R9: `cfg_restart` clears the integrators, the differentiators, the sample count and any result still being computed. No ready pulse follows in the next clock, and settling starts over.
- R10: In steady conversion no output is suppressed, including across a step in the input. After the step, the results reach the new settled value.
- R11: `res_data` changes only in a clock where `res_ready` is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator output bit |
| mod_stb | input | 1 | Marks the clock in which `mod_bit` is accepted |
| order_sel | input | 1 | 0 selects third order, 1 selects fourth order |
| rate_word | input | 10 | Block length in units of 64 samples (0 acts as 1) |
| cfg_restart | input | 1 | Single-clock pulse that loads the configuration and clears the filter |
| res_data | output | 24 | Latest valid result, two's complement |
| res_ready | output | 1 | One-clock pulse with each valid result |

## Verification
The assertions assume the following about the inputs. `mod_stb` never pulses on two consecutive clocks, so a full block always lasts longer than the serial division of the previous result. `cfg_restart` is a single-clock pulse. `order_sel` and `rate_word` are already valid when reset is released. The stimulus meets all of this by giving one sample every 16 clocks, driving every restart for exactly one clock, and setting the configuration before reset ends. The settling check counts strobes since the last configuration load against the order and length the checker latched itself. Its result therefore does not depend on the filter's own counters.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

   typedef enum logic {
      ORD_THIRD  = 1'b0,
      ORD_FOURTH = 1'b1
   } order_e;

   // Wrap-around accumulator width: n stages of growth for the longest block, plus sign.
   function automatic int acc_width(input int rate_w, input int base_lg2, input int n);
      return n * (rate_w + base_lg2) + 1;
   endfunction

endpackage

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain #(
   parameter int STAGES = 4,
   parameter int ACC_W  = 65
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clr,
   input  logic                           en,
   input  logic                           din,
   output logic [STAGES-1:0][ACC_W-1:0]   acc
);
   logic [ACC_W-1:0] step;

   // +1 for a one, -1 (all ones) for a zero
   assign step = din ? ACC_W'(1) : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (clr) begin
         acc <= '0;
      end else if (en) begin
         acc[0] <= acc[0] + step;
         for (int k = 1; k < STAGES; k++) begin
            acc[k] <= acc[k] + acc[k-1];
         end
      end
   end

endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain #(
   parameter int STAGES = 4,
   parameter int ACC_W  = 65
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         en,
   input  logic [ACC_W-1:0]             din,
   output logic [STAGES:0][ACC_W-1:0]   taps
);
   logic [STAGES-1:0][ACC_W-1:0] dly;

   assign taps[0] = din;

   for (genvar k = 0; k < STAGES; k++) begin : g_diff
      assign taps[k+1] = taps[k] - dly[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly <= '0;
      end else if (clr) begin
         dly <= '0;
      end else if (en) begin
         for (int k = 0; k < STAGES; k++) begin
            dly[k] <= taps[k];
         end
      end
   end

endmodule

// File: rtl/sinc_round_div.sv
module sinc_round_div #(
   parameter int MAG_W = 65,
   parameter int OUT_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  logic              tag,
   input  logic              neg,
   input  logic [MAG_W-1:0]  mag,
   input  logic [MAG_W-1:0]  den,
   output logic [OUT_W-1:0]  res,
   output logic              done
);
   localparam int QN    = MAG_W + OUT_W;
   localparam int CNT_W = $clog2(QN + 1);

   if (OUT_W < 4) begin : g_bad_out
      $error("sinc_round_div: OUT_W must be at least 4");
   end

   logic              busy, fin, tag_q, neg_q;
   logic [CNT_W-1:0]  cnt;
   logic [QN-1:0]     quo;
   logic [MAG_W-1:0]  rem, den_q;

   // one restoring step per clock
   logic [MAG_W:0]    trial;
   logic              ge;
   logic [MAG_W:0]    diff;
   assign trial = {rem, quo[QN-1]};
   assign ge    = trial >= {1'b0, den_q};
   assign diff  = trial - {1'b0, den_q};

   // quotient carries one extra fraction bit; round half up, then clip
   logic [OUT_W+1:0]  q_inc;
   logic [OUT_W:0]    mag_r;
   logic              over;
   logic [OUT_W-1:0]  final_v;
   assign q_inc = quo[OUT_W+1:0] + (OUT_W+2)'(1);
   assign mag_r = q_inc[OUT_W+1:1];
   assign over  = (|quo[QN-1:OUT_W+2]) || (mag_r >= ((OUT_W+1)'(1) << (OUT_W-1)));

   always_comb begin
      if (neg) begin
         final_v = '0;
      end
      if (neg_q) begin
         final_v = over ? {1'b1, {(OUT_W-1){1'b0}}} : (~mag_r[OUT_W-1:0] + OUT_W'(1));
      end else begin
         final_v = over ? {1'b0, {(OUT_W-1){1'b1}}} : mag_r[OUT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         fin   <= 1'b0;
         tag_q <= 1'b0;
         neg_q <= 1'b0;
         cnt   <= '0;
         quo   <= '0;
         rem   <= '0;
         den_q <= '0;
         res   <= '0;
         done  <= 1'b0;
      end else if (abort) begin
         busy <= 1'b0;
         fin  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            quo   <= {mag, OUT_W'(0)};
            rem   <= '0;
            den_q <= den;
            neg_q <= neg;
            tag_q <= tag;
         end else if (busy) begin
            quo <= {quo[QN-2:0], ge};
            rem <= ge ? diff[MAG_W-1:0] : trial[MAG_W-1:0];
            cnt <= cnt + CNT_W'(1);
            if (cnt == CNT_W'(QN - 1)) begin
               busy <= 1'b0;
               fin  <= 1'b1;
            end
         end
         if (fin) begin
            fin <= 1'b0;
            if (tag_q) begin
               res  <= final_v;
               done <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
   import sinc_pkg::*;
#(
   parameter int OUT_W    = 24,
   parameter int RATE_W   = 10,
   parameter int BASE_LG2 = 6,
   parameter int LO_ORDER = 3,
   parameter int HI_ORDER = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_bit,
   input  logic              mod_stb,
   input  logic              order_sel,
   input  logic [RATE_W-1:0] rate_word,
   input  logic              cfg_restart,
   output logic [OUT_W-1:0]  res_data,
   output logic              res_ready
);
   localparam int ACC_W  = acc_width(RATE_W, BASE_LG2, HI_ORDER);
   localparam int LEN_W  = RATE_W + BASE_LG2;
   localparam int TCNT_W = $clog2(HI_ORDER + 1);

   if (LO_ORDER < 1 || HI_ORDER <= LO_ORDER) begin : g_bad_order
      $error("sinc_decim: need 1 <= LO_ORDER < HI_ORDER");
   end
   if (RATE_W < 1 || BASE_LG2 < 1) begin : g_bad_len
      $error("sinc_decim: RATE_W and BASE_LG2 must be positive");
   end
   if (ACC_W > 128) begin : g_bad_acc
      $error("sinc_decim: accumulator width exceeds 128 bits");
   end

   // ---------------- configuration load ----------------
   logic   load_q, cfg_go;
   logic [RATE_W-1:0] fs_q;
   order_e ord_q;
   logic   use_hi;

   assign cfg_go = load_q | cfg_restart;
   assign use_hi = (ord_q == ORD_FOURTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_q <= 1'b1;
      else        load_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q  <= RATE_W'(1);
         ord_q <= ORD_THIRD;
      end else if (cfg_go) begin
         fs_q  <= (rate_word == '0) ? RATE_W'(1) : rate_word;
         ord_q <= order_sel ? ORD_FOURTH : ORD_THIRD;
      end
   end

   // ---------------- block length and filter gain ----------------
   logic [LEN_W-1:0]              blk_len;
   logic [HI_ORDER:1][ACC_W-1:0]  len_pow;
   logic [ACC_W-1:0]              gain_q;

   assign blk_len    = {fs_q, {BASE_LG2{1'b0}}};
   assign len_pow[1] = ACC_W'(blk_len);

   for (genvar k = 2; k <= HI_ORDER; k++) begin : g_pow
      assign len_pow[k] = len_pow[k-1] * ACC_W'(blk_len);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gain_q <= '0;
      else        gain_q <= use_hi ? len_pow[HI_ORDER] : len_pow[LO_ORDER];
   end

   // ---------------- decimation count ----------------
   logic [LEN_W-1:0] smp_cnt;
   logic             tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_cnt <= '0;
         tick_q  <= 1'b0;
      end else if (cfg_go) begin
         smp_cnt <= '0;
         tick_q  <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (mod_stb) begin
            if (smp_cnt == blk_len - LEN_W'(1)) begin
               smp_cnt <= '0;
               tick_q  <= 1'b1;
            end else begin
               smp_cnt <= smp_cnt + LEN_W'(1);
            end
         end
      end
   end

   // ---------------- integrators and differentiators ----------------
   logic [HI_ORDER-1:0][ACC_W-1:0] integ_acc;
   logic [HI_ORDER:0][ACC_W-1:0]   comb_taps;
   logic [ACC_W-1:0]               integ_out, comb_out, comb_mag;
   logic                           comb_neg;

   sinc_integ_chain #(.STAGES(HI_ORDER), .ACC_W(ACC_W)) u_integ (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cfg_go),
      .en    (mod_stb),
      .din   (mod_bit),
      .acc   (integ_acc)
   );

   assign integ_out = use_hi ? integ_acc[HI_ORDER-1] : integ_acc[LO_ORDER-1];

   sinc_comb_chain #(.STAGES(HI_ORDER), .ACC_W(ACC_W)) u_comb (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cfg_go),
      .en    (tick_q),
      .din   (integ_out),
      .taps  (comb_taps)
   );

   assign comb_out = use_hi ? comb_taps[HI_ORDER] : comb_taps[LO_ORDER];
   assign comb_neg = comb_out[ACC_W-1];
   assign comb_mag = comb_neg ? (~comb_out + ACC_W'(1)) : comb_out;

   // ---------------- settling blank ----------------
   logic [TCNT_W-1:0] tick_seen, need_ticks;
   logic              settled;

   assign need_ticks = use_hi ? TCNT_W'(HI_ORDER - 1) : TCNT_W'(LO_ORDER - 1);
   assign settled    = (tick_seen >= need_ticks);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    tick_seen <= '0;
      else if (cfg_go)               tick_seen <= '0;
      else if (tick_q && !settled)   tick_seen <= tick_seen + TCNT_W'(1);
   end

   // ---------------- normalise, round, clip ----------------
   sinc_round_div #(.MAG_W(ACC_W), .OUT_W(OUT_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .abort (cfg_go),
      .start (tick_q),
      .tag   (settled),
      .neg   (comb_neg),
      .mag   (comb_mag),
      .den   (gain_q),
      .res   (res_data),
      .done  (res_ready)
   );

endmodule

// File: rtl/sinc_decim_chk.sv
module sinc_decim_chk #(
   parameter int OUT_W    = 24,
   parameter int RATE_W   = 10,
   parameter int BASE_LG2 = 6,
   parameter int LO_ORDER = 3,
   parameter int HI_ORDER = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mod_stb,
   input logic              order_sel,
   input logic [RATE_W-1:0] rate_word,
   input logic              cfg_restart,
   input logic [OUT_W-1:0]  res_data,
   input logic              res_ready
);
   localparam int LEN_W = RATE_W + BASE_LG2;
   localparam int CNT_W = LEN_W + $clog2(HI_ORDER + 1);

   logic              ld_q, go, hi_c;
   logic [RATE_W-1:0] fs_c;
   logic [CNT_W-1:0]  stb_seen, need;

   assign go   = ld_q | cfg_restart;
   assign need = CNT_W'(hi_c ? HI_ORDER : LO_ORDER) * (CNT_W'(fs_c) << BASE_LG2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_q     <= 1'b1;
         hi_c     <= 1'b0;
         fs_c     <= RATE_W'(1);
         stb_seen <= '0;
      end else begin
         ld_q <= 1'b0;
         if (go) begin
            hi_c     <= order_sel;
            fs_c     <= (rate_word == '0) ? RATE_W'(1) : rate_word;
            stb_seen <= '0;
         end else if (mod_stb && stb_seen != '1) begin
            stb_seen <= stb_seen + CNT_W'(1);
         end
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!res_ready && res_data == '0));

   // R7
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_ready |=> !res_ready);

   // R5 R6
   settle_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_ready |-> (stb_seen >= need));

   // R9
   restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_restart |=> !res_ready);

   // R11
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_ready |-> $stable(res_data));

endmodule

bind sinc_decim sinc_decim_chk #(
   .OUT_W    (OUT_W),
   .RATE_W   (RATE_W),
   .BASE_LG2 (BASE_LG2),
   .LO_ORDER (LO_ORDER),
   .HI_ORDER (HI_ORDER)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mod_stb     (mod_stb),
   .order_sel   (order_sel),
   .rate_word   (rate_word),
   .cfg_restart (cfg_restart),
   .res_data    (res_data),
   .res_ready   (res_ready)
);

// File: tb/tb_sinc_decim.sv
`timescale 1ns/1ps
module tb_sinc_decim;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_bit = 1'b0;
   logic        mod_stb = 1'b0;
   logic        order_sel = 1'b0;
   logic [9:0]  rate_word = 10'd1;
   logic        cfg_restart = 1'b0;
   logic [23:0] res_data;
   logic        res_ready;

   always #2.5 clk = ~clk;

   sinc_decim dut (
      .clk (clk), .rst_n (rst_n), .mod_bit (mod_bit), .mod_stb (mod_stb),
      .order_sel (order_sel), .rate_word (rate_word), .cfg_restart (cfg_restart),
      .res_data (res_data), .res_ready (res_ready)
   );

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int stb_cnt = 0;
   int rdy_cnt, first_stb, last_t, min_iv, max_iv;
   bit dbl, prev_rdy;
   logic [23:0] first_data, last_data;

   always @(posedge clk) cyc <= cyc + 1;

   // observation at the falling edge
   always @(negedge clk) begin
      if (res_ready) begin
         if (prev_rdy) dbl = 1'b1;
         if (rdy_cnt == 0) begin
            first_stb  = stb_cnt;
            first_data = res_data;
         end
         if (last_t >= 0) begin
            if (cyc - last_t < min_iv) min_iv = cyc - last_t;
            if (cyc - last_t > max_iv) max_iv = cyc - last_t;
         end
         last_t    = cyc;
         last_data = res_data;
         rdy_cnt++;
      end
      prev_rdy = res_ready;
   end

   task automatic clear_stats();
      rdy_cnt = 0; first_stb = -1; last_t = -1;
      min_iv = 32'h7fffffff; max_iv = 0; dbl = 1'b0;
      first_data = '0; last_data = '0; stb_cnt = 0;
   endtask

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input string what, input longint act,
                            input longint lo, input longint hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected %0d..%0d", req, what, act, lo, hi);
      end
   endtask

   task automatic restart(input logic ord, input logic [9:0] fs);
      @(negedge clk);
      order_sel = ord; rate_word = fs; cfg_restart = 1'b1;
      @(negedge clk);
      cfg_restart = 1'b0;
      clear_stats();
   endtask

   // one accepted sample every 16 clocks, pattern bits taken LSB first
   task automatic feed(input logic [7:0] pat, input int plen, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         mod_bit = pat[i % plen];
         mod_stb = 1'b1;
         stb_cnt++;
         @(negedge clk);
         mod_stb = 1'b0;
         repeat (14) @(negedge clk);
      end
   endtask

   task automatic drain();
      repeat (200) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1", "ready right after reset", res_ready, 0);
      check("R1", "data right after reset", res_data, 0);
      repeat (3) @(negedge clk);
      check("R1", "ready idle after reset", res_ready, 0);
      check("R1", "data idle after reset", res_data, 0);
   endtask

   // full scale, settling and an input step without restart
   task automatic t_settle_step(input logic ord);
      int n = ord ? 4 : 3;
      string rq = ord ? "R6" : "R5";
      restart(ord, 10'd1);
      feed(8'hFF, 1, n * 64);
      feed(8'h00, 1, (n + 2) * 64);
      drain();
      check_rng(rq, "strobes before first ready", first_stb, n * 64, n * 64 + 8);
      check(rq, "ready count incl. step", rdy_cnt, n + 3);
      check("R2", "all ones settled", first_data, 24'h7FFFFF);
      check("R2", "all zeros settled", last_data, 24'h800000);
      check("R10", "min interval across step", min_iv, 1024);
      check("R10", "max interval across step", max_iv, 1024);
      check("R7", "ready never two clocks", dbl, 0);
   endtask

   task automatic t_density(input logic ord, input logic [9:0] fs, input logic [7:0] pat,
                            input int plen, input logic [23:0] exp_v);
      int n = ord ? 4 : 3;
      restart(ord, fs);
      feed(pat, plen, (n + 1) * 64 * int'(fs));
      drain();
      check("R3", "settled density value", last_data, exp_v);
      check("R3", "first valid density value", first_data, exp_v);
      check("R4", "interval for FS", max_iv, 1024 * int'(fs));
   endtask

   task automatic t_fs_zero();
      restart(1'b0, 10'd0);
      feed(8'hFF, 1, 5 * 64);
      drain();
      check("R4", "rate 0 ready count", rdy_cnt, 3);
      check("R4", "rate 0 interval", min_iv, 1024);
      check_rng("R4", "rate 0 first ready", first_stb, 192, 200);
   endtask

   task automatic t_cfg_hold();
      restart(1'b0, 10'd1);
      feed(8'hFF, 1, 2 * 64);
      rate_word = 10'd5;
      order_sel = 1'b1;
      feed(8'hFF, 1, 3 * 64);
      drain();
      check("R8", "ready count after live change", rdy_cnt, 3);
      check("R8", "max interval after live change", max_iv, 1024);
      check_rng("R8", "order held at third", first_stb, 192, 200);
      check("R8", "data after live change", last_data, 24'h7FFFFF);
   endtask

   task automatic t_restart_mid();
      restart(1'b0, 10'd1);
      feed(8'hFF, 1, 2 * 64 + 10);
      restart(1'b1, 10'd1);
      feed(8'h00, 1, 5 * 64);
      drain();
      check_rng("R9", "first ready after restart", first_stb, 256, 264);
      check("R9", "ready count after restart", rdy_cnt, 2);
      check("R9", "no residue of old input", first_data, 24'h800000);
   endtask

   initial begin
      clear_stats();
      prev_rdy = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_settle_step(1'b0);
      t_settle_step(1'b1);
      t_density(1'b0, 10'd2, 8'h07, 4, 24'h400000);
      t_density(1'b0, 10'd1, 8'h01, 4, 24'hC00000);
      t_density(1'b0, 10'd1, 8'h01, 2, 24'h000000);
      t_density(1'b1, 10'd1, 8'h1F, 8, 24'h200000);
      t_fs_zero();
      t_cfg_hold();
      t_restart_mid();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule